// File: doc/BRIEF.md
# Stereo Eight-Level Noise-Shaping Modulator

This block turns two streams of oversampled signed audio samples into two streams of 3-bit level codes, one code per channel on every clock, suitable for driving an eight-element DAC. The samples come from an upstream interpolation stage at one eighth of the clock rate. A one-cycle strobe marks each new left/right pair. Each pair is held for the eight clocks until the next strobe. Each channel runs its own fourth-order loop. The loop is four delaying accumulators in a chain. The quantized level is subtracted at the front end and fed back into every accumulator. The feedback weights are powers of two or sums of two of them, and they place all four loop poles at one half. This keeps the quantizer input inside the eight-level range for any input word, while the noise transfer keeps four zeros at DC.

The level of code `c` stands for the value `(2c - 7) * 2^(IN_W-2)` in input units, so a full-scale input spans about two quantizer steps. A small sequencer has two states. SQ_WAIT is entered on reset. It holds the loop cleared and both outputs at the mid-scale code 4. The transition SQ_WAIT to SQ_RUN is taken on the first strobe after reset. SQ_RUN is left only through reset, which is asynchronous and active low. Every accumulator saturates at a symmetric limit instead of wrapping.

Top module: `msdm_stereo`

## Requirements
- R1: While `rst_n` is low, both codes equal 4 and all loop state is cleared; strobes during reset have no effect on the outputs.
- R2: After reset is released, both codes stay at 4 until the first `smp_vld` strobe.
- R3: In the cycle after the edge that samples the first strobe, both codes are 4. In the cycle after that, both codes are 3, whatever the sample values.
- R4: For a constant input word `x` (two's complement, `IN_W` bits), the mean code over a long window equals `(x / 2^(IN_W-2) + 7) / 2` within 0.06.
- R5: For any input word, every code stays within 1 to 6 inclusive.
- R6: The sample inputs are latched only in a cycle with `smp_vld` high. Values present in other cycles do not change the output stream.
- R7: Left and right loops are independent: different constants on the two channels each produce their own R4 mean.
- R8: For a slowly varying input, the mean code over each 1024-cycle block matches the R4 formula applied to the mean input over the same block, within 0.08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (64 times the audio sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample pair (every 8 clocks) |
| smp_l | input | IN_W | Left sample, two's complement |
| smp_r | input | IN_W | Right sample, two's complement |
| code_l | output | LVL_W | Left level code, 0 to 7 |
| code_r | output | LVL_W | Right level code, 0 to 7 |

## Verification
The loop start and reset can meet in one cycle. A strobe may arrive in the same cycle that reset is released, or while reset is still low. The bench raises the strobe in the cycle reset goes low in mid-run and keeps it high through the reset. It then releases reset with the strobe still high. It requires mid-scale codes while reset is low, then exactly the start sequence 4 followed by 3. A second coincidence is a strobe against changing sample lines. Off-strobe cycles carry extreme opposite-sign words, and the long-run mean must still follow the latched value only.

// File: rtl/msdm_pkg.sv
package msdm_pkg;

    // Sequencer states: loop held cleared, or loop advancing every clock
    typedef enum logic [0:0] {
        SQ_WAIT = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    // Number of accumulators in the shaping loop (feedback weights are tied to this)
    localparam int LOOP_ORDER = 4;

    // Front-end weight 1/16 expressed as a right shift
    localparam int FRONT_SH = 4;

    // Number of channels
    localparam int NCH = 2;

endpackage

// File: rtl/msdm_seq.sv
module msdm_seq
    import msdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    output logic run_en,
    output logic load_en
);

    sq_state_e state_q;
    sq_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_WAIT: if (smp_vld) state_d = SQ_RUN;
            SQ_RUN:  state_d = SQ_RUN;
            default: state_d = SQ_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        run_en  = 1'b0;
        load_en = smp_vld;
        unique case (state_q)
            SQ_WAIT: run_en = 1'b0;
            SQ_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/msdm_quant.sv
module msdm_quant #(
    parameter int ST_W    = 32,
    parameter int STEP_SH = 23,
    parameter int LVL_W   = 3
) (
    input  logic signed [ST_W-1:0] u_i,
    output logic [LVL_W-1:0]       code_o
);

    localparam int NLVL = 1 << LVL_W;
    localparam int MID  = NLVL / 2;

    logic signed [ST_W-1:0] idx;

    // Mid-rise quantizer: decision thresholds at even multiples of the half step
    always_comb begin
        idx = (u_i >>> STEP_SH) + ST_W'(MID);
        if (idx < 0) begin
            code_o = '0;
        end else if (idx > ST_W'(NLVL - 1)) begin
            code_o = LVL_W'(NLVL - 1);
        end else begin
            code_o = idx[LVL_W-1:0];
        end
    end

endmodule

// File: rtl/msdm_loop.sv
module msdm_loop
    import msdm_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int ST_W  = 32,
    parameter int LVL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   load_en,
    input  logic signed [IN_W-1:0] smp_i,
    output logic [LVL_W-1:0]       code_o
);

    localparam int HS   = IN_W - 2;           // half quantizer step = 2^HS input units
    localparam int EW   = ST_W + 2;           // headroom for the saturating sums
    localparam int NLVL = 1 << LVL_W;
    localparam logic signed [EW-1:0] LIM_HI = EW'((64'sd1 <<< (ST_W - 1)) - 64'sd1);
    localparam logic signed [EW-1:0] LIM_LO = -LIM_HI;

    logic signed [IN_W-1:0] x_q;
    logic signed [ST_W-1:0] st_q [LOOP_ORDER];
    logic signed [ST_W-1:0] st_d [LOOP_ORDER];
    logic signed [EW-1:0]   inc  [LOOP_ORDER];
    logic signed [EW-1:0]   sum  [LOOP_ORDER];
    logic [LVL_W-1:0]       q_code;
    logic signed [LVL_W+1:0] lvl;
    logic signed [EW-1:0]   y_e;
    logic signed [EW-1:0]   x_e;

    msdm_quant #(
        .ST_W   (ST_W),
        .STEP_SH(HS + 1),
        .LVL_W  (LVL_W)
    ) u_quant (
        .u_i   (st_q[LOOP_ORDER-1]),
        .code_o(q_code)
    );

    // Feedback level and stage inputs. Weights 1/16, 1/2, 3/2, 2 put all poles at 0.5.
    always_comb begin
        lvl = $signed({1'b0, q_code, 1'b0}) - $signed((LVL_W + 2)'(NLVL - 1));
        y_e = EW'(lvl) <<< HS;
        x_e = EW'(x_q);
        inc[0] = (x_e - y_e) >>> FRONT_SH;
        inc[1] = EW'(st_q[0]) - (y_e >>> 1);
        inc[2] = EW'(st_q[1]) - (y_e + (y_e >>> 1));
        inc[3] = EW'(st_q[2]) - (y_e <<< 1);
        for (int k = 0; k < LOOP_ORDER; k++) begin
            sum[k] = EW'(st_q[k]) + inc[k];
            if (sum[k] > LIM_HI) begin
                st_d[k] = LIM_HI[ST_W-1:0];
            end else if (sum[k] < LIM_LO) begin
                st_d[k] = LIM_LO[ST_W-1:0];
            end else begin
                st_d[k] = sum[k][ST_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            for (int k = 0; k < LOOP_ORDER; k++) begin
                st_q[k] <= '0;
            end
        end else begin
            if (load_en) begin
                x_q <= smp_i;
            end
            if (run_en) begin
                for (int k = 0; k < LOOP_ORDER; k++) begin
                    st_q[k] <= st_d[k];
                end
            end
        end
    end

    assign code_o = run_en ? q_code : LVL_W'(NLVL / 2);

endmodule

// File: rtl/msdm_stereo.sv
module msdm_stereo
    import msdm_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int ST_W  = 32,
    parameter int LVL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic signed [IN_W-1:0] smp_l,
    input  logic signed [IN_W-1:0] smp_r,
    output logic [LVL_W-1:0]       code_l,
    output logic [LVL_W-1:0]       code_r
);

    logic run_en;
    logic load_en;
    logic [LVL_W-1:0] code_ch [NCH];

    msdm_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_vld(smp_vld),
        .run_en (run_en),
        .load_en(load_en)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [IN_W-1:0] smp_ch;
        assign smp_ch = (ch == 0) ? smp_l : smp_r;

        msdm_loop #(
            .IN_W (IN_W),
            .ST_W (ST_W),
            .LVL_W(LVL_W)
        ) u_loop (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (run_en),
            .load_en(load_en),
            .smp_i  (smp_ch),
            .code_o (code_ch[ch])
        );
    end

    assign code_l = code_ch[0];
    assign code_r = code_ch[1];

endmodule

// File: rtl/msdm_stereo_chk.sv
module msdm_stereo_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [LVL_W-1:0] code_l,
    input logic [LVL_W-1:0] code_r
);

    localparam int NLVL = 1 << LVL_W;
    localparam logic [LVL_W-1:0] MID  = LVL_W'(NLVL / 2);
    localparam logic [LVL_W-1:0] LO_C = LVL_W'(1);
    localparam logic [LVL_W-1:0] HI_C = LVL_W'(NLVL - 2);

    logic [1:0] since_go;
    logic       rst_seen = 1'b0;

    // Cycles since the first strobe after reset, saturating at 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_go <= 2'd0;
        end else if (since_go == 2'd0) begin
            if (smp_vld) since_go <= 2'd1;
        end else if (since_go != 2'd3) begin
            since_go <= since_go + 2'd1;
        end
    end

    // R1: reset holds mid-scale (checked once reset has been seen at an earlier edge)
    always @(posedge clk) begin
        if (rst_seen && !rst_n) begin
            p_mid_in_reset_r1: assert (code_l == MID && code_r == MID)
                else $error("R1 code not mid-scale in reset");
        end
        rst_seen <= !rst_n;
    end

    p_mid_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_go == 2'd0) |-> (code_l == MID && code_r == MID));

    p_first_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_go == 2'd1) |-> (code_l == MID && code_r == MID));

    p_first_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_go == 2'd2) |-> (code_l == MID - 1'b1 && code_r == MID - 1'b1));

    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_l >= LO_C && code_l <= HI_C && code_r >= LO_C && code_r <= HI_C));

endmodule

bind msdm_stereo msdm_stereo_chk #(.LVL_W(LVL_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_vld(smp_vld),
    .code_l (code_l),
    .code_r (code_r)
);

// File: tb/test_msdm_stereo.sv
module test_msdm_stereo;

    localparam int IN_W = 24;
    localparam int HALF = 1 << (IN_W - 2);
    localparam int FS_P = (1 << (IN_W - 1)) - 1;
    localparam int FS_N = -(1 << (IN_W - 1));

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [IN_W-1:0] smp_l = '0;
    logic signed [IN_W-1:0] smp_r = '0;
    logic [2:0] code_l;
    logic [2:0] code_r;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    bit  meas = 1'b0;
    bit  track = 1'b0;
    real acc_l, acc_r, acc_xl, acc_xr;
    int  n_acc;
    int  oor = 0;
    int  held_l, held_r;
    int  frame_no = 0;

    msdm_stereo i_msdm_stereo (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_vld(smp_vld),
        .smp_l  (smp_l),
        .smp_r  (smp_r),
        .code_l (code_l),
        .code_r (code_r)
    );

    function automatic real exp_mean(input real x);
        return (x / real'(HALF) + 7.0) / 2.0;
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_real(input string req, input string what, input real act,
                              input real exp, input real tol);
        n_chk++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s %s: actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge
    task automatic drive(input bit v, input int l, input int r);
        @(negedge clk);
        smp_vld = v;
        smp_l   = l[IN_W-1:0];
        smp_r   = r[IN_W-1:0];
        @(posedge clk);
        #1;
        if (track && (code_l < 3'd1 || code_l > 3'd6 || code_r < 3'd1 || code_r > 3'd6))
            oor++;
        if (meas) begin
            acc_l  += real'(code_l);
            acc_r  += real'(code_r);
            acc_xl += real'(held_l);
            acc_xr += real'(held_r);
            n_acc++;
        end
    endtask

    // One sample period of eight clocks; optional hostile values between strobes
    task automatic frame(input int l, input int r, input bit garb);
        int gl;
        int gr;
        gl = (l < 0) ? FS_P : FS_N;
        gr = (r < 0) ? FS_P : FS_N;
        held_l = l;
        held_r = r;
        drive(1'b1, l, r);
        for (int i = 0; i < 7; i++) begin
            if (garb) drive(1'b0, gl, gr);
            else      drive(1'b0, l, r);
        end
        frame_no++;
    endtask

    task automatic clear_acc();
        acc_l = 0.0; acc_r = 0.0; acc_xl = 0.0; acc_xr = 0.0; n_acc = 0;
    endtask

    task automatic const_test(input string req, input int l, input int r, input bit garb);
        meas = 1'b0;
        for (int i = 0; i < 64; i++) frame(l, r, garb);
        clear_acc();
        meas = 1'b1;
        for (int i = 0; i < 512; i++) frame(l, r, garb);
        meas = 1'b0;
        check_real(req, $sformatf("left mean x=%0d", l), acc_l / n_acc, exp_mean(real'(l)), 0.06);
        check_real(req, $sformatf("right mean x=%0d", r), acc_r / n_acc, exp_mean(real'(r)), 0.06);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_acc();

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_int("R1", "left code in reset", int'(code_l), 4);
        check_int("R1", "right code in reset", int'(code_r), 4);

        // R2: idle after release, no strobe
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) drive(1'b0, FS_P, FS_N);
        check_int("R2", "left code before start", int'(code_l), 4);
        check_int("R2", "right code before start", int'(code_r), 4);

        // R3: start sequence
        drive(1'b1, FS_P, FS_N);
        check_int("R3", "left first code", int'(code_l), 4);
        drive(1'b0, FS_P, FS_N);
        check_int("R3", "right second code", int'(code_r), 3);
        check_int("R3", "left second code", int'(code_l), 3);
        for (int i = 0; i < 6; i++) drive(1'b0, FS_P, FS_N);
        track = 1'b1;

        // R4 / R7 / R5 / R6 directed constants
        const_test("R4", 0, 0, 1'b0);
        const_test("R7", HALF, -HALF, 1'b0);
        const_test("R5", FS_N, FS_P, 1'b0);
        check_int("R5", "codes outside 1..6 at full scale", oor, 0);
        const_test("R6", 1048576, -3145728, 1'b1);

        // R4: random constants
        for (int t = 0; t < 4; t++) begin
            int rl;
            int rr;
            rl = int'($urandom_range(2 * FS_P, 0)) - FS_P;
            rr = int'($urandom_range(2 * FS_P, 0)) - FS_P;
            const_test("R4", rl, rr, 1'b0);
        end

        // R8: slow sines, block means
        frame_no = 0;
        for (int f = 0; f < 128; f++)
            frame($rtoi(6291456.0 * $sin(6.283185307 * f / 1024.0)),
                  $rtoi(6291456.0 * $sin(6.283185307 * f / 512.0 + 1.0)), 1'b0);
        for (int b = 0; b < 16; b++) begin
            clear_acc();
            meas = 1'b1;
            for (int f = 0; f < 128; f++) begin
                int fi;
                fi = 128 + b * 128 + f;
                frame($rtoi(6291456.0 * $sin(6.283185307 * fi / 1024.0)),
                      $rtoi(6291456.0 * $sin(6.283185307 * fi / 512.0 + 1.0)), 1'b0);
            end
            meas = 1'b0;
            check_real("R8", $sformatf("left block %0d mean", b), acc_l / n_acc,
                       exp_mean(acc_xl / n_acc), 0.08);
            check_real("R8", $sformatf("right block %0d mean", b), acc_r / n_acc,
                       exp_mean(acc_xr / n_acc), 0.08);
        end

        // R1 / R3: reset in mid-run with strobe, then release with strobe
        @(negedge clk);
        rst_n   = 1'b0;
        smp_vld = 1'b1;
        smp_l   = FS_P[IN_W-1:0];
        smp_r   = FS_N[IN_W-1:0];
        @(posedge clk);
        #1;
        check_int("R1", "left code on mid-run reset", int'(code_l), 4);
        check_int("R1", "right code on mid-run reset", int'(code_r), 4);
        repeat (3) @(posedge clk);
        #1;
        check_int("R1", "left code with strobe in reset", int'(code_l), 4);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_int("R3", "left code after release with strobe", int'(code_l), 4);
        check_int("R3", "right code after release with strobe", int'(code_r), 4);
        drive(1'b0, 0, 0);
        check_int("R3", "left code second after restart", int'(code_l), 3);
        check_int("R3", "right code second after restart", int'(code_r), 3);
        for (int i = 0; i < 200; i++) frame(-HALF, HALF, 1'b0);

        check_int("R5", "codes outside 1..6 overall", oor, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule